// File: doc/BRIEF.md
# Command/Response Ring Pointer Controller

This block is the hardware half of a circular command ring in a host controller. Software places command slots in a ring, then writes an enqueue pointer. The block keeps its own dequeue pointer. While the ring is running and the two pointers differ, it offers the slot at its dequeue pointer to an executor through a valid/ready handshake. Only one command is outstanding at a time. When the executor returns a response, the dequeue pointer moves one slot forward. The pointer wraps modulo the programmed ring size, and a completion or error interrupt is recorded. Slot indices stand in for descriptor addresses.

Software controls the ring through a word-addressed register port. Writes take effect at a clock edge and reads are combinational. The ring has enable, run/stop and abort controls with status readback. Software can reset the pointers. The interrupt logic has a write-one-to-clear status register, a status-enable mask that decides which events latch, a signal-enable mask that decides which latched bits drive the interrupt line, and a force register for testing each interrupt path.

Top module: `cmdring_ptr_ctrl`

## Requirements
- R1: After reset the following all read zero: status (address 2), the first and second operation registers (addresses 3 and 4) and interrupt status (address 5). The setup register (address 0) reads the default ring size of 16. `irq` and `cmd_valid` are low.
- R2: The first operation register (address 3) is read/write. It holds the enqueue pointer in [7:0], the software response dequeue pointer in [15:8] and the in-band interrupt dequeue pointer in [23:16]. The second operation register (address 4) is read-only. It holds the hardware dequeue pointer in [7:0] and the in-band interrupt enqueue pointer in [23:16], which is always 0 here. Writes to it are ignored.
- R3: The ring size is set in setup bits [8:0]. Every pointer advance wraps to 0 when it reaches the size. A write to setup clears all pointers to 0.
- R4: `cmd_valid` is high only when the ring is running, the hardware dequeue pointer differs from the enqueue pointer, and no command is outstanding. `cmd_slot` equals the hardware dequeue pointer.
- R5: A response (`rsp_valid`) that arrives while a command is outstanding advances the hardware dequeue pointer by one. With `rsp_err` low it sets transfer completion (interrupt bit 11). With `rsp_err` high it sets transfer error (bit 9).
- R6: The control register (address 1) has enable in bit 0, run/stop in bit 1 and abort in bit 2. Status (address 2) reports enabled in bit 0, running in bit 1, aborted in bit 2 and locked in bit 3. Locked means a command is outstanding.
- R7: Writing enable with abort while the ring is running has these effects at that edge: running clears, aborted sets, and ring operation (bit 10) is set. If a command is outstanding, transfer abort (bit 5) is also set, and that command's response is still accepted.
- R8: Writing enable alone keeps the ring stopped and keeps aborted. Writing enable with run/stop then sets running and clears aborted.
- R9: Writing 1 to a bit of interrupt status (address 5) clears that bit.
- R10: An event or forced bit latches into interrupt status only if its bit in status-enable (address 6) is set. Only bits 12, 11, 10, 9, 6 and 5 exist.
- R11: `irq` is high exactly when some interrupt status bit and the same bit of signal-enable (address 7) are both 1.
- R12: Writing the force register (address 8) sets the given status bits in that cycle, subject to R10. The register itself reads 0.
- R13: Writing all zeros to the first operation register also returns the hardware dequeue pointer to 0.
- R14: A response that arrives with no command outstanding is ignored. It changes no pointer and no interrupt status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_valid | output | 1 | A command slot is offered |
| cmd_slot | output | 8 | Index of the offered slot |
| cmd_ready | input | 1 | Executor accepts the offered slot |
| rsp_valid | input | 1 | Executor returns a response |
| rsp_err | input | 1 | Response carries an error |
| irq | output | 1 | Interrupt line |

## Verification
Every result is due right after the clock edge that takes its stimulus. A register write is visible after its edge. A response moves the dequeue pointer and latches its interrupt bit at the same edge. An abort clears running and latches its interrupt bits at that edge. `cmd_valid` and `irq` are combinational from that state. The bench drives every input at a falling edge and samples at the next falling edge or shortly after it, one edge after the stimulus. The bench's model of the executor checks every offered slot against its own modulo count.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 4;
  localparam int PTR_W  = 8;
  localparam int SIZE_W = 9;

  typedef enum logic [REG_AW-1:0] {
    RA_SETUP  = 4'd0,
    RA_CTRL   = 4'd1,
    RA_STATUS = 4'd2,
    RA_OPA    = 4'd3,
    RA_OPB    = 4'd4,
    RA_ISTAT  = 4'd5,
    RA_ISEN   = 4'd6,
    RA_IGEN   = 4'd7,
    RA_IFRC   = 4'd8
  } reg_addr_e;

  // interrupt bit positions (decoded by software)
  localparam int IB_IBI_RDY  = 12;
  localparam int IB_DONE     = 11;
  localparam int IB_RINGOP   = 10;
  localparam int IB_XERR     = 9;
  localparam int IB_IBI_FULL = 6;
  localparam int IB_XABORT   = 5;

  localparam logic [REG_W-1:0] IRQ_IMPL =
    (REG_W'(1) << IB_IBI_RDY) | (REG_W'(1) << IB_DONE) |
    (REG_W'(1) << IB_RINGOP)  | (REG_W'(1) << IB_XERR) |
    (REG_W'(1) << IB_IBI_FULL) | (REG_W'(1) << IB_XABORT);

  // one-step advance of a ring pointer, wrapping at the ring size
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] n;
    n = SIZE_W'(p) + SIZE_W'(1);
    if (n >= sz) return '0;
    return n[PTR_W-1:0];
  endfunction
endpackage

// File: rtl/crr_ctrl.sv
module crr_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [2:0] ctrl_wdata,
  input  logic       locked,
  output logic       enabled,
  output logic       running,
  output logic       aborted,
  output logic       ringop_ev,
  output logic       xabort_ev
);
  logic abort_hit;

  // abort accepted only while running
  assign abort_hit = ctrl_wr && ctrl_wdata[0] && ctrl_wdata[2] && running;
  assign ringop_ev = abort_hit;
  assign xabort_ev = abort_hit && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      running <= 1'b0;
      aborted <= 1'b0;
    end else if (ctrl_wr) begin
      if (!ctrl_wdata[0]) begin
        enabled <= 1'b0;
        running <= 1'b0;
        aborted <= 1'b0;
      end else if (ctrl_wdata[2]) begin
        enabled <= 1'b1;
        if (running) begin
          running <= 1'b0;
          aborted <= 1'b1;
        end
      end else begin
        enabled <= 1'b1;
        running <= ctrl_wdata[1];
        if (ctrl_wdata[1]) aborted <= 1'b0;
      end
    end
  end

  a_r7_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[0] && ctrl_wdata[2] && running) |=> (!running && aborted));

  a_r6_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> enabled);

  a_r8_restart_clears_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata == 3'b011) |=> (running && !aborted));
endmodule

// File: rtl/crr_issue.sv
module crr_issue
  import cmdring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [SIZE_W-1:0] size,
  input  logic [PTR_W-1:0]  enq,
  input  logic              clr_ptr,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              cmd_valid,
  output logic [PTR_W-1:0]  cmd_slot,
  output logic [PTR_W-1:0]  hw_deq,
  output logic              locked,
  output logic              done_ev,
  output logic              err_ev
);
  logic ring_empty, fire, rsp_take;

  assign ring_empty = (hw_deq == enq);
  assign cmd_valid  = running && !ring_empty && !locked;
  assign cmd_slot   = hw_deq;
  assign fire       = cmd_valid && cmd_ready;
  assign rsp_take   = rsp_valid && locked;
  assign done_ev    = rsp_take && !rsp_err;
  assign err_ev     = rsp_take && rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_deq <= '0;
      locked <= 1'b0;
    end else begin
      if (clr_ptr)       hw_deq <= '0;
      else if (rsp_take) hw_deq <= ptr_next(hw_deq, size);
      if (fire)          locked <= 1'b1;
      else if (rsp_take) locked <= 1'b0;
    end
  end

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmd_valid && cmd_ready));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && locked && !clr_ptr) |=> (hw_deq == ptr_next($past(hw_deq), $past(size))));

  a_r14_stray_response: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !locked && !clr_ptr) |=> $stable(hw_deq));

  a_r4_no_offer_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !cmd_valid);
endmodule

// File: rtl/crr_irq.sv
module crr_irq
  import cmdring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ev,
  input  logic             wr_stat,
  input  logic             wr_sen,
  input  logic             wr_gen,
  input  logic             wr_frc,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] istat,
  output logic [REG_W-1:0] stat_en,
  output logic [REG_W-1:0] sig_en,
  output logic             irq
);
  logic [REG_W-1:0] frc_vec, set_vec, clr_vec;

  assign frc_vec = wr_frc  ? wdata : '0;
  assign clr_vec = wr_stat ? wdata : '0;
  assign set_vec = (ev | frc_vec) & stat_en & IRQ_IMPL;
  assign irq     = |(istat & sig_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat   <= '0;
      stat_en <= '0;
      sig_en  <= '0;
    end else begin
      istat <= (istat & ~clr_vec) | set_vec;   // a new event wins over a clear
      if (wr_sen) stat_en <= wdata & IRQ_IMPL;
      if (wr_gen) sig_en  <= wdata & IRQ_IMPL;
    end
  end

  a_r10_masked_never_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((istat & ~$past(istat) & ~$past(stat_en)) == '0));

  a_r9_clear_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && ev == '0) |=> ((istat & $past(wdata)) == '0));

  a_r11_irq_needs_signal: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en == '0) |-> !irq);
endmodule

// File: rtl/cmdring_ptr_ctrl.sv
module cmdring_ptr_ctrl
  import cmdring_pkg::*;
#(
  parameter logic [SIZE_W-1:0] DEFAULT_SIZE = 9'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              cmd_valid,
  output logic [PTR_W-1:0]  cmd_slot,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              irq
);
  logic [SIZE_W-1:0] size_q;
  logic [PTR_W-1:0]  enq_q, swdeq_q, ibideq_q, hw_deq;
  logic              wr_setup, wr_ctrl, wr_opa, clr_ptr;
  logic              enabled, running, aborted, locked;
  logic              ringop_ev, xabort_ev, done_ev, err_ev;
  logic [REG_W-1:0]  irq_ev, istat, stat_en, sig_en;

  assign wr_setup = reg_wr && (reg_addr == RA_SETUP);
  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_opa   = reg_wr && (reg_addr == RA_OPA);
  assign clr_ptr  = wr_setup || (wr_opa && reg_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= DEFAULT_SIZE;
      enq_q    <= '0;
      swdeq_q  <= '0;
      ibideq_q <= '0;
    end else if (wr_setup) begin
      size_q   <= reg_wdata[SIZE_W-1:0];
      enq_q    <= '0;
      swdeq_q  <= '0;
      ibideq_q <= '0;
    end else if (wr_opa) begin
      enq_q    <= reg_wdata[PTR_W-1:0];
      swdeq_q  <= reg_wdata[2*PTR_W-1:PTR_W];
      ibideq_q <= reg_wdata[3*PTR_W-1:2*PTR_W];
    end
  end

  crr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (wr_ctrl),
    .ctrl_wdata(reg_wdata[2:0]),
    .locked    (locked),
    .enabled   (enabled),
    .running   (running),
    .aborted   (aborted),
    .ringop_ev (ringop_ev),
    .xabort_ev (xabort_ev)
  );

  crr_issue u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .size     (size_q),
    .enq      (enq_q),
    .clr_ptr  (clr_ptr),
    .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .cmd_valid(cmd_valid),
    .cmd_slot (cmd_slot),
    .hw_deq   (hw_deq),
    .locked   (locked),
    .done_ev  (done_ev),
    .err_ev   (err_ev)
  );

  always_comb begin
    irq_ev = '0;
    irq_ev[IB_DONE]   = done_ev;
    irq_ev[IB_XERR]   = err_ev;
    irq_ev[IB_RINGOP] = ringop_ev;
    irq_ev[IB_XABORT] = xabort_ev;
  end

  crr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (irq_ev),
    .wr_stat(reg_wr && (reg_addr == RA_ISTAT)),
    .wr_sen (reg_wr && (reg_addr == RA_ISEN)),
    .wr_gen (reg_wr && (reg_addr == RA_IGEN)),
    .wr_frc (reg_wr && (reg_addr == RA_IFRC)),
    .wdata  (reg_wdata),
    .istat  (istat),
    .stat_en(stat_en),
    .sig_en (sig_en),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SETUP:  reg_rdata[SIZE_W-1:0] = size_q;
      RA_CTRL:   reg_rdata[1:0] = {running, enabled};
      RA_STATUS: reg_rdata[3:0] = {locked, aborted, running, enabled};
      RA_OPA:    reg_rdata[3*PTR_W-1:0] = {ibideq_q, swdeq_q, enq_q};
      RA_OPB:    reg_rdata[PTR_W-1:0] = hw_deq;
      RA_ISTAT:  reg_rdata = istat;
      RA_ISEN:   reg_rdata = stat_en;
      RA_IGEN:   reg_rdata = sig_en;
      default:   reg_rdata = '0;
    endcase
  end

  a_r13_zero_write_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opa && reg_wdata == '0) |=> (hw_deq == '0));

  a_r3_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setup |=> (hw_deq == '0 && enq_q == '0));
endmodule

// File: tb/cmdring_ptr_ctrl_test.sv
`timescale 1ns/100ps
module cmdring_ptr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic [7:0]  cmd_slot;
  logic        cmd_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int mptr = 0;
  int msize = 16;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmdring_ptr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_slot(cmd_slot), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .irq(irq)
  );

  typedef struct packed {
    logic [8:0] size;     // 0 = keep current size
    logic [7:0] enq;
    logic       err;
    logic [8:0] n;        // commands expected to issue
    logic [7:0] exp_deq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{9'd5,   8'd3,   1'b0, 9'd3,   8'd3},
    '{9'd0,   8'd1,   1'b0, 9'd3,   8'd1},
    '{9'd0,   8'd2,   1'b1, 9'd1,   8'd2},
    '{9'd8,   8'd7,   1'b0, 9'd7,   8'd7},
    '{9'd0,   8'd0,   1'b1, 9'd1,   8'd0},
    '{9'd255, 8'd254, 1'b0, 9'd254, 8'd254},
    '{9'd0,   8'd1,   1'b0, 9'd2,   8'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic serve(input int n, input logic err);
    for (int i = 0; i < n; i++) begin
      int t = 0;
      while (!cmd_valid && t < 50) begin @(negedge clk); t++; end
      check("R4 offer", {31'd0, cmd_valid}, 32'd1);
      check("R4 slot", {24'd0, cmd_slot}, mptr[31:0]);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0; rsp_valid = 1'b1; rsp_err = err;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
      mptr = (mptr + 1) % msize;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd2, d); check("R1 status", d, 32'h0);
    rd(4'd3, d); check("R1 opA", d, 32'h0);
    rd(4'd4, d); check("R1 opB", d, 32'h0);
    rd(4'd5, d); check("R1 istat", d, 32'h0);
    rd(4'd0, d); check("R1 setup", d, 32'd16);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);

    // R4: nothing offered while not running
    wr(4'd3, 32'h0000_0102);
    wr(4'd1, 32'h1);
    @(negedge clk);
    check("R4 stopped no offer", {31'd0, cmd_valid}, 32'd0);

    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, d); check("R10 enable implemented bits", d, 32'h0000_1E60);
    wr(4'd1, 32'h3);
    rd(4'd2, d); check("R6 running", d, 32'h3);

    // table walk: R3 R5
    for (int v = 0; v < 7; v++) begin
      if (VECS[v].size != 9'd0) begin
        wr(4'd0, {23'd0, VECS[v].size});
        mptr = 0; msize = int'(VECS[v].size);
      end
      wr(4'd3, {16'h0001, VECS[v].enq});
      serve(int'(VECS[v].n), VECS[v].err);
      @(negedge clk);
      check("R4 empty no offer", {31'd0, cmd_valid}, 32'd0);
      rd(4'd4, d); check("R3 R5 hw dequeue", d, {24'd0, VECS[v].exp_deq});
      rd(4'd5, d);
      check("R5 completion/error bit", d & 32'h0000_0A00,
            VECS[v].err ? 32'h0000_0200 : 32'h0000_0800);
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, d); check("R9 clear", d, 32'h0);
    end
    rd(4'd0, d); check("R3 setup readback", d, 32'd255);

    // R14 stray response
    @(negedge clk);
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    rd(4'd4, d); check("R14 pointer unchanged", d, 32'd1);
    rd(4'd5, d); check("R14 no status", d, 32'h0);

    // R7 abort with an outstanding command
    wr(4'd3, 32'h0000_0103);
    check("R4 offer slot", {24'd0, cmd_slot}, 32'd1);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    rd(4'd2, d); check("R6 locked", d, 32'hB);
    check("R4 single outstanding", {31'd0, cmd_valid}, 32'd0);
    wr(4'd1, 32'h5);
    rd(4'd2, d); check("R7 aborted status", d, 32'hD);
    rd(4'd5, d); check("R7 ringop and xabort", d, 32'h0000_0420);
    @(negedge clk);
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    rd(4'd4, d); check("R7 response accepted", d, 32'd2);
    rd(4'd2, d); check("R7 unlocked", d, 32'h5);
    check("R4 no offer aborted", {31'd0, cmd_valid}, 32'd0);

    // R8 restart sequence
    wr(4'd1, 32'h1);
    rd(4'd2, d); check("R8 enable only", d, 32'h5);
    wr(4'd1, 32'h3);
    rd(4'd2, d); check("R8 running again", d, 32'h3);
    mptr = 2;
    serve(1, 1'b0);
    rd(4'd4, d); check("R8 resumed", d, 32'd3);

    // R2 and R13
    wr(4'd1, 32'h1);
    wr(4'd3, 32'h0);
    rd(4'd4, d); check("R13 zero write", d, 32'h0);
    wr(4'd3, 32'h00AB_CD12);
    rd(4'd3, d); check("R2 opA readback", d, 32'h00AB_CD12);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, d); check("R2 opB read-only", d, 32'h0);

    // R12 R10 R11 R9
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd6, 32'h0000_1000);
    wr(4'd8, 32'h0000_1040);
    rd(4'd5, d); check("R12 R10 forced gated", d, 32'h0000_1000);
    rd(4'd8, d); check("R12 force reads zero", d, 32'h0);
    check("R11 irq masked", {31'd0, irq}, 32'd0);
    wr(4'd7, 32'h0000_1000);
    check("R11 irq raised", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'h0000_1000);
    rd(4'd5, d); check("R9 single clear", d, 32'h0);
    check("R11 irq drops", {31'd0, irq}, 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule